// File: doc/BRIEF.md
# PWM Submodule Synchronizable Time Base

This block is the time base behind one PWM channel group. A 16-bit counter advances by one on every submodule clock. When a chosen initialization event occurs, the counter restarts from a programmable start value. Four sources can act as that event: the block's own modulus compare, a master reload strobe, a master sync strobe, or an external sync input. A force input can also act as the event when it is enabled. If the local compare is chosen, the modulus and start values alone set the PWM period.

The block also holds active copies of the modulus and half-cycle compare values. These copies change only at reload events, and only while a load-okay flag is armed. Reload opportunities arise at the full-cycle compare, at the half-cycle compare, or at both. A divider lets only every Nth opportunity become a local reload. A select input makes transfers follow either the local reload or the master reload input. Every opportunity is still reported on its own output pulse.

Top module: `pwm_timebase`

## Requirements
- R1: `count` increases by exactly one (modulo 2^16) on each clock that has no initialization event. Reset clears `count`, `load_ok` and every pulse output, and copies `mod_buf`/`half_buf` into `act_mod`/`act_half`.
- R2: `local_sync` is high for the cycle following any cycle in which `count` equals `act_mod`.
- R3: With `init_src` = 0 (local), `count` runs from `init_val` up to `act_mod` and restarts. The period is `act_mod - init_val + 1` cycles, and `count` equals `init_val` whenever `local_sync` is high.
- R4: `init_src` = 1 selects `mstr_reload`, 2 selects `mstr_sync` and 3 selects `ext_sync`. A high level on the selected input loads `init_val` at the next edge. The two unselected inputs leave counting unchanged.
- R5: `force_in` loads `init_val` at the next edge only when `force_en` is 1. With `force_en` = 0 it has no effect.
- R6: `act_mod` and `act_half` change only at a reload event that finds `load_ok` set. At that edge they take the `mod_buf`/`half_buf` values.
- R7: A `load_ok_set` pulse sets `load_ok`. A transfer clears it.
- R8: A reload opportunity occurs when `count` equals `act_mod` with `full_en` = 1, or when `count` equals `act_half` with `half_en` = 1. `reload_opp` is high the cycle after each opportunity.
- R9: With `reload_div` = N-1, `local_reload` is high for the cycle after the Nth, 2Nth, 3Nth and later opportunities since reset, and is low otherwise.
- R10: `reload_src` = 0 makes local reloads the transfer event. `reload_src` = 1 makes `mstr_reload` the transfer event, and local reloads then cause no transfer.
- R11: When an initialization event and a modulus compare coincide, `count` loads `init_val` and `local_sync` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Submodule clock |
| rst | input | 1 | Synchronous active-high reset |
| init_val | input | 16 | Counter start value |
| mod_buf | input | 16 | Buffered modulus value |
| half_buf | input | 16 | Buffered half-cycle compare value |
| init_src | input | 2 | Init source: 0 local, 1 master reload, 2 master sync, 3 external |
| reload_src | input | 1 | Transfer event: 0 local reload, 1 master reload |
| full_en | input | 1 | Reload opportunity at modulus compare |
| half_en | input | 1 | Reload opportunity at half compare |
| reload_div | input | 4 | Opportunities per local reload, minus one |
| ext_sync | input | 1 | External sync strobe |
| mstr_sync | input | 1 | Master sync strobe from the lead submodule |
| mstr_reload | input | 1 | Master reload strobe from the lead submodule |
| force_in | input | 1 | Force strobe |
| force_en | input | 1 | Lets force_in initialize the counter |
| load_ok_set | input | 1 | Arms the load-okay flag |
| count | output | 16 | Counter value |
| local_sync | output | 1 | Registered modulus-compare pulse |
| local_reload | output | 1 | Registered local reload pulse |
| reload_opp | output | 1 | Registered reload-opportunity pulse |
| load_ok | output | 1 | Load-okay flag |
| act_mod | output | 16 | Active modulus value |
| act_half | output | 16 | Active half compare value |

## Verification
The hardest situation to reach is an init strobe that lands on the exact cycle of a modulus compare. The stimulus selects the external source, watches `count` until it shows the active modulus, and raises `ext_sync` for that one cycle. The divider phase needs care as well. Each divider setting starts from a fresh reset so that the opportunity count starts at zero. The bench then compares every registered pulse against that running count modulo N.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic [1:0] {
    SRC_LOCAL   = 2'd0,
    SRC_MRELOAD = 2'd1,
    SRC_MSYNC   = 2'd2,
    SRC_EXT     = 2'd3
  } init_src_e;
endpackage

// File: rtl/ptb_counter.sv
module ptb_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_val,
  input  logic [1:0]    init_src,
  input  logic          mod_hit,
  input  logic          mstr_reload,
  input  logic          mstr_sync,
  input  logic          ext_sync,
  input  logic          force_in,
  input  logic          force_en,
  output logic [CW-1:0] cnt
);
  import ptb_pkg::*;

  init_src_e src;
  logic      sel_ev;
  logic      init_ev;

  assign src = init_src_e'(init_src);

  always_comb begin
    case (src)
      SRC_LOCAL:   sel_ev = mod_hit;
      SRC_MRELOAD: sel_ev = mstr_reload;
      SRC_MSYNC:   sel_ev = mstr_sync;
      default:     sel_ev = ext_sync;
    endcase
  end

  assign init_ev = sel_ev | (force_en & force_in);

  // init has priority over counting, including on a modulus hit (R11)
  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (init_ev) cnt <= init_val;
    else              cnt <= cnt + 1'b1;
  end

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (!init_ev && !$past(rst)) |=> cnt == $past(cnt) + 1'b1);
  a_r4_init_load: assert property (@(posedge clk) disable iff (rst)
    init_ev |=> cnt == $past(init_val));
  a_r5_force_gated: assert property (@(posedge clk) disable iff (rst)
    (force_in && !force_en && !sel_ev) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/ptb_divider.sv
module ptb_divider #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opp,
  input  logic [DW-1:0] div_n,
  output logic          fire
);
  logic [DW-1:0] dcnt;

  assign fire = opp && (dcnt >= div_n);

  always_ff @(posedge clk) begin
    if (rst)       dcnt <= '0;
    else if (fire) dcnt <= '0;
    else if (opp)  dcnt <= dcnt + 1'b1;
  end

  a_r9_fire_on_opp: assert property (@(posedge clk) disable iff (rst)
    fire |-> opp);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!opp && !$past(rst)) |=> $stable(dcnt));
endmodule

// File: rtl/ptb_reload.sv
module ptb_reload #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rel_ev,
  input  logic          load_ok_set,
  input  logic [CW-1:0] mod_buf,
  input  logic [CW-1:0] half_buf,
  output logic [CW-1:0] act_mod,
  output logic [CW-1:0] act_half,
  output logic          load_ok
);
  logic xfer;

  assign xfer = rel_ev & load_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mod  <= mod_buf;
      act_half <= half_buf;
      load_ok  <= 1'b0;
    end else begin
      if (xfer) begin
        act_mod  <= mod_buf;
        act_half <= half_buf;
      end
      load_ok <= load_ok_set | (load_ok & ~xfer);
    end
  end

  a_r6_hold_unarmed: assert property (@(posedge clk) disable iff (rst)
    (!load_ok && !$past(rst)) |=> ($stable(act_mod) && $stable(act_half)));
  a_r7_clear_on_xfer: assert property (@(posedge clk) disable iff (rst)
    (rel_ev && load_ok && !load_ok_set) |=> !load_ok);
  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    load_ok_set |=> load_ok);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] mod_buf,
  input  logic [CW-1:0] half_buf,
  input  logic [1:0]    init_src,
  input  logic          reload_src,
  input  logic          full_en,
  input  logic          half_en,
  input  logic [DW-1:0] reload_div,
  input  logic          ext_sync,
  input  logic          mstr_sync,
  input  logic          mstr_reload,
  input  logic          force_in,
  input  logic          force_en,
  input  logic          load_ok_set,
  output logic [CW-1:0] count,
  output logic          local_sync,
  output logic          local_reload,
  output logic          reload_opp,
  output logic          load_ok,
  output logic [CW-1:0] act_mod,
  output logic [CW-1:0] act_half
);
  logic mod_hit;
  logic half_hit;
  logic opp;
  logic loc_fire;
  logic rel_ev;

  assign mod_hit  = (count == act_mod);
  assign half_hit = (count == act_half);
  assign opp      = (full_en & mod_hit) | (half_en & half_hit);
  assign rel_ev   = reload_src ? mstr_reload : loc_fire;

  ptb_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .init_val(init_val), .init_src(init_src),
    .mod_hit(mod_hit), .mstr_reload(mstr_reload), .mstr_sync(mstr_sync),
    .ext_sync(ext_sync), .force_in(force_in), .force_en(force_en),
    .cnt(count)
  );

  ptb_divider #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .opp(opp), .div_n(reload_div), .fire(loc_fire)
  );

  ptb_reload #(.CW(CW)) u_rel (
    .clk(clk), .rst(rst), .rel_ev(rel_ev), .load_ok_set(load_ok_set),
    .mod_buf(mod_buf), .half_buf(half_buf),
    .act_mod(act_mod), .act_half(act_half), .load_ok(load_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      local_sync   <= 1'b0;
      local_reload <= 1'b0;
      reload_opp   <= 1'b0;
    end else begin
      local_sync   <= mod_hit;
      local_reload <= loc_fire;
      reload_opp   <= opp;
    end
  end

  a_r2_sync_follows: assert property (@(posedge clk) disable iff (rst)
    mod_hit |=> local_sync);
  a_r8_half_opp: assert property (@(posedge clk) disable iff (rst)
    (half_en && half_hit) |=> reload_opp);
  a_r9_reload_subset: assert property (@(posedge clk) disable iff (rst)
    local_reload |-> reload_opp);
  a_r10_master_only: assert property (@(posedge clk) disable iff (rst)
    (reload_src && !mstr_reload && !$past(rst)) |=> $stable(act_mod));
endmodule

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] init_val = '0, mod_buf = 16'd3, half_buf = 16'd1;
  logic [1:0]  init_src = 2'd0;
  logic        reload_src = 1'b0, full_en = 1'b1, half_en = 1'b0;
  logic [3:0]  reload_div = '0;
  logic        ext_sync = 0, mstr_sync = 0, mstr_reload = 0;
  logic        force_in = 0, force_en = 0, load_ok_set = 0;
  logic [15:0] count, act_mod, act_half;
  logic        local_sync, local_reload, reload_opp, load_ok;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_timebase uut (
    .clk(clk), .rst(rst), .init_val(init_val), .mod_buf(mod_buf),
    .half_buf(half_buf), .init_src(init_src), .reload_src(reload_src),
    .full_en(full_en), .half_en(half_en), .reload_div(reload_div),
    .ext_sync(ext_sync), .mstr_sync(mstr_sync), .mstr_reload(mstr_reload),
    .force_in(force_in), .force_en(force_en), .load_ok_set(load_ok_set),
    .count(count), .local_sync(local_sync), .local_reload(local_reload),
    .reload_opp(reload_opp), .load_ok(load_ok), .act_mod(act_mod),
    .act_half(act_half)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic drive_src(input int j, input logic v);
    case (j)
      1: mstr_reload = v;
      2: mstr_sync   = v;
      default: ext_sync = v;
    endcase
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c, t, k;
    // R1 reset state
    init_val = 16'd0; mod_buf = 16'd7; half_buf = 16'd2;
    do_reset();
    chk("R1 reset count", count, 0);
    chk("R1 reset load_ok", load_ok, 0);
    chk("R1 reset act_mod", act_mod, 7);
    chk("R1 reset act_half", act_half, 2);
    chk("R1 reset sync", local_sync, 0);
    tick();
    chk("R1 step", count, 1);

    // R2/R3 local period sweep
    for (int i = 0; i < 3; i++) begin
      for (int d = 0; d < 6; d++) begin
        init_val = (i == 2) ? 16'd3 : 16'(i);
        mod_buf  = init_val + 16'(d);
        init_src = 2'd0;
        do_reset();
        t = 0;
        while (!local_sync && t < 50) begin tick(); t++; end
        chk("R2 sync seen", local_sync, 1);
        chk("R3 count at sync", count, init_val);
        t = 0;
        do begin tick(); t++; end while (!local_sync && t < 50);
        chk("R3 period", t, d + 1);
      end
    end

    // R4 init source selection
    for (int s = 1; s < 4; s++) begin
      init_val = 16'd2; mod_buf = 16'd200; init_src = 2'(s);
      do_reset();
      for (int j = 1; j < 4; j++) begin
        tick(); tick();
        c = count;
        drive_src(j, 1'b1);
        tick();
        drive_src(j, 1'b0);
        chk((j == s) ? "R4 selected loads" : "R4 unselected ignored",
            count, (j == s) ? 2 : c + 1);
      end
    end

    // R5 force gating
    init_src = 2'd1;
    tick(); tick();
    c = count;
    force_in = 1; force_en = 0;
    tick();
    chk("R5 force disabled", count, c + 1);
    force_en = 1;
    tick();
    chk("R5 force enabled", count, 2);
    force_in = 0; force_en = 0;

    // R8 opportunity counts, period 4
    init_src = 2'd0; init_val = 16'd0; mod_buf = 16'd3; half_buf = 16'd1;
    reload_div = 4'd0;
    for (int m = 0; m < 3; m++) begin
      full_en = (m != 2); half_en = (m != 0);
      do_reset();
      k = 0;
      for (int n = 0; n < 40; n++) begin
        tick();
        if (reload_opp) begin
          k++;
          if (m == 2) chk("R8 half-only position", count, 2);
        end
      end
      chk("R8 opportunity count", k, (m == 1) ? 20 : 10);
    end

    // R9 reload divider
    full_en = 1; half_en = 0;
    for (int nn = 1; nn <= 5; nn++) begin
      reload_div = 4'(nn - 1);
      do_reset();
      k = 0;
      for (int n = 0; n < 60; n++) begin
        tick();
        if (reload_opp) k++;
        chk("R9 divided reload", local_reload, reload_opp && (k % nn == 0));
      end
    end

    // R6/R7 load-okay gating, local reload
    reload_div = 4'd0; reload_src = 0;
    mod_buf = 16'd3;
    do_reset();
    mod_buf = 16'd5;
    for (int n = 0; n < 12; n++) tick();
    chk("R6 no transfer unarmed", act_mod, 3);
    load_ok_set = 1;
    tick();
    load_ok_set = 0;
    chk("R7 armed", load_ok, 1);
    t = 0;
    while (!reload_opp && t < 20) begin tick(); t++; end
    chk("R6 transfer at reload", act_mod, 5);
    chk("R7 cleared by transfer", load_ok, 0);
    while (!local_sync) tick();
    t = 0;
    do begin tick(); t++; end while (!local_sync && t < 50);
    chk("R6 new period", t, 6);

    // R10 master reload selection
    reload_src = 1; mod_buf = 16'd7;
    load_ok_set = 1;
    tick();
    load_ok_set = 0;
    for (int n = 0; n < 10; n++) tick();
    chk("R10 local reload ignored", act_mod, 5);
    chk("R10 still armed", load_ok, 1);
    mstr_reload = 1;
    tick();
    mstr_reload = 0;
    chk("R10 master transfer", act_mod, 7);
    chk("R10 flag cleared", load_ok, 0);
    reload_src = 0;

    // R11 init and compare in the same cycle
    init_val = 16'd4; mod_buf = 16'd9; init_src = 2'd3;
    do_reset();
    t = 0;
    while (count != 16'd9 && t < 50) begin tick(); t++; end
    ext_sync = 1;
    tick();
    ext_sync = 0;
    chk("R11 init wins", count, 4);
    chk("R11 sync pulses", local_sync, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule